// File: doc/BRIEF.md
# Disk Interface Interrupt Cause Register Block

This block gathers the two interrupt causes of a disk interface into one level interrupt line. One cause is an interrupt raised by the attached drive. The other is a memory or bus fault seen while a DMA transfer is running. Each cause arrives as a one-cycle pulse. The pulse sets a sticky pending bit, and that bit stays set until software clears it. Software reaches the block through a small single-cycle register port. A status register reports the pending bits. A write-one-to-set register arms the causes that may drive the interrupt line. A write-one-to-clear register acknowledges pending bits.

A bus fault also carries the 64-bit address of the failed access. The block keeps the address of the first fault in two read-only words at the bottom of the register window. Later faults do not replace that address until software has acknowledged the fault bit. The interrupt line is high whenever an armed cause is pending.

Top module: `irq_cause_regs`

## Requirements
- R1: After synchronous reset the pending bits, the arm mask and the captured fault address are all zero, and `irq_o` is low.
- R2: A pulse on `dev_irq_pulse` sets pending bit 0 and a pulse on `bus_err_pulse` sets pending bit 1. Both bits are visible in bits [1:0] of a read at byte address 0x0C, and the upper bits read as zero.
- R3: A write to byte address 0x1C clears each pending bit whose write-data bit ([0] drive, [1] fault) is one. Zero bits leave the matching pending bit unchanged.
- R4: A cause pulse in the same cycle as a clear write of its bit wins, so the pending bit is still set afterwards.
- R5: A write to byte address 0x14 sets each arm-mask bit whose write-data bit is one. Zero bits have no effect. A read of 0x14 returns the mask in bits [1:0].
- R6: `irq_o` is high exactly when some pending bit and its arm-mask bit are both set, from the cycle after the state changes.
- R7: When pending bit 1 goes from 0 to 1, the fault address is captured. Its low word reads at byte address 0x00 and its high word at 0x04.
- R8: While pending bit 1 stays set, further fault pulses do not change the captured address. The first fault after the bit has been cleared captures again.
- R9: Writes to 0x00, 0x04, 0x0C or any unmapped or unaligned address change nothing. Reads of 0x1C and of unmapped or unaligned addresses return zero.
- R10: Read data appears on `reg_rdata` in the cycle after a read select and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq_pulse | input | 1 | One-cycle drive interrupt event |
| bus_err_pulse | input | 1 | One-cycle DMA memory/bus fault event |
| bus_err_addr | input | 64 | Address of the faulted access, valid with `bus_err_pulse` |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The assertions assume that a cause pulse lasts one cycle and that `bus_err_addr` is meaningful only while `bus_err_pulse` is high. They also assume that a register access is a single strobe with a stable address and data in that cycle. The stimulus drives every input on the falling edge and returns each pulse and strobe to zero on the next falling edge. It sets fault addresses only together with a fault pulse, so the address-hold checks see exactly the intended capture events.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int FADDR_W    = 64;
    localparam int NSRC       = 2;
    localparam int SRC_DEV    = 0;
    localparam int SRC_FAULT  = 1;

    // byte addresses = word index * 4
    localparam int WIDX_FLO   = 0;
    localparam int WIDX_FHI   = 1;
    localparam int WIDX_STAT  = 3;
    localparam int WIDX_ARM   = 5;
    localparam int WIDX_ACK   = 7;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_FLO,
        RS_FHI,
        RS_STAT,
        RS_ARM,
        RS_ACK
    } reg_slot_e;

    typedef struct packed {
        logic [NSRC-1:0] arm_ones;
        logic [NSRC-1:0] ack_ones;
        logic            rd;
        reg_slot_e       slot;
    } reg_cmd_t;

    function automatic reg_slot_e slot_of(input logic [ADDR_W-1:0] a);
        reg_slot_e s;
        s = RS_NONE;
        if (a[1:0] == 2'b00) begin
            case (int'(a[ADDR_W-1:2]))
                WIDX_FLO:  s = RS_FLO;
                WIDX_FHI:  s = RS_FHI;
                WIDX_STAT: s = RS_STAT;
                WIDX_ARM:  s = RS_ARM;
                WIDX_ACK:  s = RS_ACK;
                default:   s = RS_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_cause_decode.sv
module irq_cause_decode
    import irq_cause_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output reg_cmd_t          cmd
);
    reg_slot_e slot;

    always_comb begin
        slot         = slot_of(addr);
        cmd.slot     = slot;
        cmd.rd       = sel && !wr;
        cmd.arm_ones = '0;
        cmd.ack_ones = '0;
        if (sel && wr && slot == RS_ARM) cmd.arm_ones = wdata[NSRC-1:0];
        if (sel && wr && slot == RS_ACK) cmd.ack_ones = wdata[NSRC-1:0];
    end
endmodule

// File: rtl/irq_cause_bits.sv
module irq_cause_bits
    import irq_cause_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] ack_ones,
    input  logic [NSRC-1:0] arm_ones,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] arm
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g] <= 1'b0;
            end else if (evt[g]) begin
                pend[g] <= 1'b1;
            end else if (ack_ones[g]) begin
                pend[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                arm[g] <= 1'b0;
            end else if (arm_ones[g]) begin
                arm[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_cause_fcap.sv
module irq_cause_fcap
    import irq_cause_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fault_evt,
    input  logic               fault_pend,
    input  logic [FADDR_W-1:0] fault_addr,
    output logic [FADDR_W-1:0] held_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_addr <= '0;
        end else if (fault_evt && !fault_pend) begin
            held_addr <= fault_addr;
        end
    end
endmodule

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
    import irq_cause_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               dev_irq_pulse,
    input  logic               bus_err_pulse,
    input  logic [FADDR_W-1:0] bus_err_addr,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_o
);
    reg_cmd_t           cmd;
    logic [NSRC-1:0]    evt;
    logic [NSRC-1:0]    pend_q;
    logic [NSRC-1:0]    arm_q;
    logic [FADDR_W-1:0] faddr_q;
    logic [DATA_W-1:0]  rd_mux;

    always_comb begin
        evt            = '0;
        evt[SRC_DEV]   = dev_irq_pulse;
        evt[SRC_FAULT] = bus_err_pulse;
    end

    irq_cause_decode u_dec (
        .sel   (reg_sel),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cmd   (cmd)
    );

    irq_cause_bits u_bits (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .ack_ones (cmd.ack_ones),
        .arm_ones (cmd.arm_ones),
        .pend     (pend_q),
        .arm      (arm_q)
    );

    irq_cause_fcap u_fcap (
        .clk        (clk),
        .rst        (rst),
        .fault_evt  (bus_err_pulse),
        .fault_pend (pend_q[SRC_FAULT]),
        .fault_addr (bus_err_addr),
        .held_addr  (faddr_q)
    );

    always_comb begin
        rd_mux = '0;
        case (cmd.slot)
            RS_FLO:  rd_mux = faddr_q[DATA_W-1:0];
            RS_FHI:  rd_mux = faddr_q[FADDR_W-1:DATA_W];
            RS_STAT: rd_mux[NSRC-1:0] = pend_q;
            RS_ARM:  rd_mux[NSRC-1:0] = arm_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (cmd.rd) begin
            reg_rdata <= rd_mux;
        end
    end

    assign irq_o = |(pend_q & arm_q);
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
    import irq_cause_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               dev_irq_pulse,
    input logic               bus_err_pulse,
    input logic               reg_sel,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [NSRC-1:0]    pend_q,
    input logic [NSRC-1:0]    arm_q,
    input logic [FADDR_W-1:0] faddr_q,
    input logic               irq_o
);
    logic ack_wr;
    assign ack_wr = reg_sel && reg_wr && reg_addr == 8'h1C;

    // R3
    ack_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && reg_wdata[0] && !dev_irq_pulse) |=> !pend_q[0]);

    // R4
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_err_pulse && ack_wr && reg_wdata[1]) |=> pend_q[1]);

    // R5
    arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        arm_q[1] |=> arm_q[1]);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q[1] |=> $stable(faddr_q));

    // R9
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr && reg_addr == 8'h0C && !dev_irq_pulse && !bus_err_pulse)
        |=> $stable(pend_q));

    // R6
    irq_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (arm_q == '0) |-> !irq_o);
endmodule

bind irq_cause_regs irq_cause_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .dev_irq_pulse (dev_irq_pulse),
    .bus_err_pulse (bus_err_pulse),
    .reg_sel       (reg_sel),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .pend_q        (pend_q),
    .arm_q         (arm_q),
    .faddr_q       (faddr_q),
    .irq_o         (irq_o)
);

// File: tb/irq_cause_regs_tb.sv
module irq_cause_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dev_irq_pulse = 1'b0;
    logic        bus_err_pulse = 1'b0;
    logic [63:0] bus_err_addr = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    bit [1:0]  m_pend;
    bit [1:0]  m_arm;
    bit [63:0] m_addr;
    bit [31:0] m_rdata;

    always #10 clk = ~clk;

    irq_cause_regs u_dut (
        .clk           (clk),
        .rst           (rst),
        .dev_irq_pulse (dev_irq_pulse),
        .bus_err_pulse (bus_err_pulse),
        .bus_err_addr  (bus_err_addr),
        .reg_sel       (reg_sel),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq_o         (irq_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] model_read(input bit [7:0] a);
        case (a)
            8'h00:   return m_addr[31:0];
            8'h04:   return m_addr[63:32];
            8'h0C:   return {30'b0, m_pend};
            8'h14:   return {30'b0, m_arm};
            default: return 32'b0;
        endcase
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        bit [1:0] ack;
        bit [1:0] setm;
        bit [1:0] ev;
        if (rst) begin
            m_pend = 0; m_arm = 0; m_addr = 0; m_rdata = 0;
        end else begin
            ack  = (reg_sel && reg_wr && reg_addr == 8'h1C) ? reg_wdata[1:0] : 2'b0;
            setm = (reg_sel && reg_wr && reg_addr == 8'h14) ? reg_wdata[1:0] : 2'b0;
            ev   = {bus_err_pulse, dev_irq_pulse};
            if (reg_sel && !reg_wr) m_rdata = model_read(reg_addr);
            if (bus_err_pulse && !m_pend[1]) m_addr = bus_err_addr;
            m_pend = (m_pend & ~ack) | ev;
            m_arm  = m_arm | setm;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 irq_o vs model", irq_o, (m_pend & m_arm) != 0);
            chk("R10 reg_rdata vs model", reg_rdata, m_rdata);
        end
    end

    task automatic idle();
        @(negedge clk);
        reg_sel = 0; reg_wr = 0; dev_irq_pulse = 0; bus_err_pulse = 0;
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(negedge clk);
        reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        idle();
    endtask

    task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
        @(negedge clk);
        reg_sel = 1; reg_wr = 0; reg_addr = a;
        idle();
        chk(tag, reg_rdata, exp);
    endtask

    task automatic fault(input bit [63:0] a);
        @(negedge clk);
        bus_err_pulse = 1; bus_err_addr = a;
        idle();
    endtask

    task automatic dev();
        @(negedge clk);
        dev_irq_pulse = 1;
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 irq_o after reset", irq_o, 0);
        rd(8'h0C, 0, "R1 pending after reset");
        rd(8'h14, 0, "R1 arm after reset");
        rd(8'h00, 0, "R1 fault low after reset");
        rd(8'h04, 0, "R1 fault high after reset");

        dev();
        rd(8'h0C, 32'h1, "R2 drive bit set");
        chk("R6 unarmed no irq", irq_o, 0);

        wr(8'h14, 32'h0);
        rd(8'h14, 0, "R5 zero arm write");
        wr(8'h14, 32'hFFFF_FFFD);
        rd(8'h14, 32'h1, "R5 arm bit0 only");
        chk("R6 armed drive irq", irq_o, 1);

        wr(8'h1C, 32'h2);
        rd(8'h0C, 32'h1, "R3 zero bit keeps drive pending");
        wr(8'h1C, 32'h1);
        rd(8'h0C, 0, "R3 clear drive bit");
        chk("R6 irq drops after clear", irq_o, 0);

        fault(64'h1234_5678_9ABC_DEF0);
        rd(8'h0C, 32'h2, "R2 fault bit set");
        rd(8'h00, 32'h9ABC_DEF0, "R7 fault low word");
        rd(8'h04, 32'h1234_5678, "R7 fault high word");
        chk("R6 fault unarmed", irq_o, 0);
        wr(8'h14, 32'h2);
        chk("R6 fault armed irq", irq_o, 1);

        fault(64'hAAAA_BBBB_CCCC_DDDD);
        rd(8'h00, 32'h9ABC_DEF0, "R8 low word held");
        rd(8'h04, 32'h1234_5678, "R8 high word held");

        // cause and clear in same cycle
        @(negedge clk);
        dev_irq_pulse = 1; reg_sel = 1; reg_wr = 1; reg_addr = 8'h1C; reg_wdata = 32'h3;
        idle();
        rd(8'h0C, 32'h1, "R4 drive event beats clear");

        @(negedge clk);
        bus_err_pulse = 1; bus_err_addr = 64'h5555_0000_6666_0000;
        idle();
        @(negedge clk);
        bus_err_pulse = 1; bus_err_addr = 64'h7777_7777_8888_8888;
        reg_sel = 1; reg_wr = 1; reg_addr = 8'h1C; reg_wdata = 32'h2;
        idle();
        rd(8'h0C, 32'h3, "R4 fault event beats clear");
        rd(8'h00, 32'h6666_0000, "R8 no recapture on simultaneous clear");

        wr(8'h1C, 32'h3);
        fault(64'h0F0F_0F0F_F0F0_F0F0);
        rd(8'h04, 32'h0F0F_0F0F, "R8 recapture after clear");

        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h1D, 32'hFFFF_FFFF);
        rd(8'h00, 32'hF0F0_F0F0, "R9 write to low word ignored");
        rd(8'h0C, 32'h2, "R9 write to status ignored");
        rd(8'h1C, 0, "R9 clear register reads zero");
        rd(8'h30, 0, "R9 unmapped reads zero");
        rd(8'h0E, 0, "R9 unaligned reads zero");

        rd(8'h14, 32'h3, "R10 read arm");
        repeat (3) @(negedge clk);
        chk("R10 rdata holds when idle", reg_rdata, 32'h3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule